// File: doc/BRIEF.md
# Multi-thread reset vector loader

After a synchronous reset, this block brings up the architectural context of every hardware thread, one thread at a time. For each thread it reads an eight-byte start address from a vector table through a byte-wide synchronous memory read port. It packs those bytes into the thread's 64-bit program counter. The general registers, stack pointer and stack identifier of each thread are set to fixed reset values.

Thread 0 takes its start address from a dedicated vector at 0xFFC0. Every other thread takes it from a shared table at 0xFF50, with eight bytes per slot, so slot `i-1` serves thread `i`. When a thread's eighth byte lands, that thread's start strobe pulses for one cycle. After the last thread has been started, a global done flag rises and stays high until the next reset.

The memory has one cycle of read latency. The loader issues one byte address per cycle and captures the returned byte one cycle after it appears, so loading all threads takes about eight cycles per thread.

Top module: `thread_boot_loader`

## Requirements
- R1: Thread 0 reads bytes from addresses 0xFFC0 up to 0xFFC7, in rising order.
- R2: Thread i (i >= 1) reads from 0xFF50 + 8*(i-1) + k for k = 0..7, in rising order, so the addresses within one vector step by exactly one.
- R3: The byte read at vector offset k fills bits 8k+7..8k of the thread's program counter (little-endian). The full value is present while the thread's start strobe is high.
- R4: Each thread's stack pointer reads 0xFFFF and its stack identifier reads thread index + 1, during reset and afterwards.
- R5: The four general registers of every thread (packed as index 0..3 per thread, thread-major) read zero, during reset and afterwards.
- R6: Reads start on the first clock edge after reset is released. There is one read per cycle, threads go in ascending order, and there are exactly 8*NUM_THREADS reads with none after that.
- R7: Thread t's start strobe is high for exactly one cycle, after clock edge 8t+10 counted from reset release. At most one strobe is high at a time.
- R8: Done rises one cycle after the last thread's strobe, at edge 8*NUM_THREADS+3, and then stays high.
- R9: Reset asserted in the middle of loading clears done, the strobes, the read request and all program counters. After release the whole sequence restarts from thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_data | input | 8 | Read data, valid one cycle after the request |
| ctx_pc | output | NUM_THREADS*PC_W | Program counters, thread 0 in the low bits |
| ctx_gpr | output | NUM_THREADS*4*PC_W | General registers, four per thread |
| ctx_sp | output | NUM_THREADS*SP_W | Stack pointers |
| ctx_stk_id | output | NUM_THREADS*4 | Stack identifiers |
| thread_start | output | NUM_THREADS | One-cycle start strobe per thread |
| boot_done | output | 1 | All threads loaded |

## Verification
Edges are counted from the release of reset:

| Result | After edge |
|---|---|
| Read for global byte j on the port | j+1 |
| Byte j captured | j+3 |
| Strobe of thread t | 8t+10 |
| Done | 8*NUM_THREADS+3 |

The bench counts edges in the same way and samples on the falling edge that follows each one. At every such point it compares the read port, the strobes and done against that schedule. The program counter of each thread is compared in the cycle its strobe is high, against a value the bench assembles itself from its memory model.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int MAX_THREADS = 8;
  localparam int TID_W       = 3;
  localparam int BYTE_W      = 3;
  localparam int VEC_BYTES   = 1 << BYTE_W;
  localparam int SID_W       = 4;
  localparam int GPR_COUNT   = 4;

  typedef struct packed {
    logic [TID_W-1:0]  tid;
    logic [BYTE_W-1:0] bsel;
  } fetch_tag_t;
endpackage

// File: rtl/boot_vec_addr.sv
module boot_vec_addr
  import boot_pkg::*;
#(
  parameter int               ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE   = 16'hFFC0,
  parameter logic [ADDR_W-1:0] SHARED_BASE = 16'hFF50
) (
  input  fetch_tag_t        tag,
  output logic [ADDR_W-1:0] addr
);
  logic [TID_W-1:0]        slot;
  logic [TID_W+BYTE_W-1:0] offs;

  always_comb begin
    slot = tag.tid - TID_W'(1);
    offs = {slot, tag.bsel};
    if (tag.tid == '0) addr = BOOT_BASE + ADDR_W'(tag.bsel);
    else               addr = SHARED_BASE + ADDR_W'(offs);
  end
endmodule

// File: rtl/boot_fetch_seq.sv
module boot_fetch_seq
  import boot_pkg::*;
#(
  parameter int               NUM_THREADS = 4,
  parameter int               ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE   = 16'hFFC0,
  parameter logic [ADDR_W-1:0] SHARED_BASE = 16'hFF50
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              cap_vld_o,
  output fetch_tag_t        cap_tag_o
);
  localparam logic [TID_W-1:0]  LAST_TID  = TID_W'(NUM_THREADS - 1);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(VEC_BYTES - 1);

  fetch_tag_t        cur_q, iss_tag_q, cap_tag_q;
  logic              active_q, rd_q, cap_vld_q;
  logic [ADDR_W-1:0] addr_q, next_addr;

  boot_vec_addr #(
    .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE), .SHARED_BASE(SHARED_BASE)
  ) u_addr (
    .tag(cur_q), .addr(next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q     <= '0;
      active_q  <= 1'b1;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      iss_tag_q <= '0;
      cap_vld_q <= 1'b0;
      cap_tag_q <= '0;
    end else begin
      rd_q      <= active_q;
      cap_vld_q <= rd_q;
      cap_tag_q <= iss_tag_q;
      if (active_q) begin
        addr_q    <= next_addr;
        iss_tag_q <= cur_q;
        if (cur_q.bsel == LAST_BYTE) begin
          cur_q.bsel <= '0;
          if (cur_q.tid == LAST_TID) active_q <= 1'b0;
          else cur_q.tid <= cur_q.tid + TID_W'(1);
        end else begin
          cur_q.bsel <= cur_q.bsel + BYTE_W'(1);
        end
      end
    end
  end

  assign mem_rd_o   = rd_q;
  assign mem_addr_o = addr_q;
  assign cap_vld_o  = cap_vld_q;
  assign cap_tag_o  = cap_tag_q;

  assert_addr_consecutive_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_q && iss_tag_q.bsel != '0) |-> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/boot_ctx_bank.sv
module boot_ctx_bank
  import boot_pkg::*;
#(
  parameter int               NUM_THREADS = 4,
  parameter int               PC_W        = 64,
  parameter int               SP_W        = 16,
  parameter logic [SP_W-1:0]  SP_RESET    = 16'hFFFF
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cap_vld,
  input  fetch_tag_t                          cap_tag,
  input  logic [7:0]                          cap_byte,
  output logic [NUM_THREADS*PC_W-1:0]         pc_o,
  output logic [NUM_THREADS*GPR_COUNT*PC_W-1:0] gpr_o,
  output logic [NUM_THREADS*SP_W-1:0]         sp_o,
  output logic [NUM_THREADS*SID_W-1:0]        sid_o,
  output logic [NUM_THREADS-1:0]              start_o
);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(VEC_BYTES - 1);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ctx
    logic [PC_W-1:0]           pc_q;
    logic [GPR_COUNT*PC_W-1:0] gpr_q;
    logic [SP_W-1:0]           sp_q;
    logic [SID_W-1:0]          sid_q;
    logic                      start_q;
    logic                      hit;

    assign hit = cap_vld && (cap_tag.tid == TID_W'(t));

    always_ff @(posedge clk) begin
      if (rst) begin
        pc_q    <= '0;
        gpr_q   <= '0;
        sp_q    <= SP_RESET;
        sid_q   <= SID_W'(t + 1);
        start_q <= 1'b0;
      end else begin
        start_q <= hit && (cap_tag.bsel == LAST_BYTE);
        if (hit) pc_q[{cap_tag.bsel, 3'b000} +: 8] <= cap_byte;
      end
    end

    assign pc_o[t*PC_W +: PC_W]                         = pc_q;
    assign gpr_o[t*GPR_COUNT*PC_W +: GPR_COUNT*PC_W]    = gpr_q;
    assign sp_o[t*SP_W +: SP_W]                         = sp_q;
    assign sid_o[t*SID_W +: SID_W]                      = sid_q;
    assign start_o[t]                                   = start_q;
  end

  assert_single_start_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_o));
endmodule

// File: rtl/thread_boot_loader.sv
module thread_boot_loader
  import boot_pkg::*;
#(
  parameter int               NUM_THREADS = 4,
  parameter int               ADDR_W      = 16,
  parameter int               PC_W        = 64,
  parameter int               SP_W        = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE   = 16'hFFC0,
  parameter logic [ADDR_W-1:0] SHARED_BASE = 16'hFF50,
  parameter logic [SP_W-1:0]  SP_RESET    = 16'hFFFF
) (
  input  logic                                  clk,
  input  logic                                  rst,
  output logic                                  mem_rd,
  output logic [ADDR_W-1:0]                     mem_addr,
  input  logic [7:0]                            mem_data,
  output logic [NUM_THREADS*PC_W-1:0]           ctx_pc,
  output logic [NUM_THREADS*GPR_COUNT*PC_W-1:0] ctx_gpr,
  output logic [NUM_THREADS*SP_W-1:0]           ctx_sp,
  output logic [NUM_THREADS*SID_W-1:0]          ctx_stk_id,
  output logic [NUM_THREADS-1:0]                thread_start,
  output logic                                  boot_done
);
  logic       cap_vld;
  fetch_tag_t cap_tag;
  logic       done_q;

  boot_fetch_seq #(
    .NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W),
    .BOOT_BASE(BOOT_BASE), .SHARED_BASE(SHARED_BASE)
  ) u_seq (
    .clk(clk), .rst(rst), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .cap_vld_o(cap_vld), .cap_tag_o(cap_tag)
  );

  boot_ctx_bank #(
    .NUM_THREADS(NUM_THREADS), .PC_W(PC_W), .SP_W(SP_W), .SP_RESET(SP_RESET)
  ) u_bank (
    .clk(clk), .rst(rst), .cap_vld(cap_vld), .cap_tag(cap_tag),
    .cap_byte(mem_data), .pc_o(ctx_pc), .gpr_o(ctx_gpr), .sp_o(ctx_sp),
    .sid_o(ctx_stk_id), .start_o(thread_start)
  );

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else if (thread_start[NUM_THREADS-1]) done_q <= 1'b1;
  end

  assign boot_done = done_q;

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);
  assert_done_follows_last_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(thread_start[NUM_THREADS-1]));
  assert_quiet_after_done_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !mem_rd);
endmodule

// File: tb/test_thread_boot_loader.sv
`timescale 1ns/1ps
module test_thread_boot_loader;
  localparam int N    = 4;
  localparam int PC_W = 64;
  localparam int SP_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic [N*PC_W-1:0]   ctx_pc;
  logic [N*4*PC_W-1:0] ctx_gpr;
  logic [N*SP_W-1:0]   ctx_sp;
  logic [N*4-1:0]      ctx_stk_id;
  logic [N-1:0]        thread_start;
  logic                boot_done;

  logic [7:0] vmem [256];
  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  thread_boot_loader #(.NUM_THREADS(N)) i_thread_boot_loader (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .ctx_pc(ctx_pc), .ctx_gpr(ctx_gpr), .ctx_sp(ctx_sp),
    .ctx_stk_id(ctx_stk_id), .thread_start(thread_start), .boot_done(boot_done)
  );

  always_ff @(posedge clk) if (mem_rd) mem_data <= vmem[mem_addr[7:0]];

  function automatic logic [15:0] vec_addr(input int t, input int k);
    if (t == 0) return 16'hFFC0 + 16'(k);
    return 16'hFF50 + 16'(8 * (t - 1) + k);
  endfunction

  function automatic logic [63:0] exp_pc(input int t);
    logic [63:0] v = '0;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = vmem[vec_addr(t, k) & 16'h00FF];
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_ctx_static();
    for (int t = 0; t < N; t++) begin
      chk("R4 sp", 64'(ctx_sp[t*SP_W +: SP_W]), 64'hFFFF);
      chk("R4 stk id", 64'(ctx_stk_id[t*4 +: 4]), 64'(t + 1));
      for (int g = 0; g < 4; g++)
        chk("R5 gpr", ctx_gpr[(t*4+g)*PC_W +: PC_W], 64'h0);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 done in reset", 64'(boot_done), 64'h0);
    chk("R9 rd in reset", 64'(mem_rd), 64'h0);
    chk("R9 start in reset", 64'(thread_start), 64'h0);
    chk("R9 pc in reset", 64'(|ctx_pc), 64'h0);
    check_ctx_static();
    rst = 1'b0;
  endtask

  task automatic run_load(input int stop_at);
    for (int n = 1; n <= stop_at; n++) begin
      @(negedge clk);
      chk("R6 read strobe", 64'(mem_rd), 64'((n >= 1) && (n <= 8*N)));
      if (n <= 8*N) begin
        if ((n - 1) / 8 == 0) chk("R1 address", 64'(mem_addr), 64'(vec_addr(0, (n-1) % 8)));
        else chk("R2 address", 64'(mem_addr), 64'(vec_addr((n-1) / 8, (n-1) % 8)));
      end
      for (int t = 0; t < N; t++) begin
        chk("R7 start", 64'(thread_start[t]), 64'(n == 8*t + 10));
        if (n == 8*t + 10) chk("R3 pc", ctx_pc[t*PC_W +: PC_W], exp_pc(t));
      end
      chk("R8 done", 64'(boot_done), 64'(n >= 8*N + 3));
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    void'($urandom(32'd2024));
    // directed: byte value equals its own low address, exposes byte order
    for (int i = 0; i < 256; i++) vmem[i] = 8'(i);
    apply_reset();
    run_load(8*N + 8);
    check_ctx_static();
    // directed: all ones
    for (int i = 0; i < 256; i++) vmem[i] = 8'hFF;
    apply_reset();
    run_load(8*N + 8);
    // random contents
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 256; i++) vmem[i] = 8'($urandom);
      apply_reset();
      run_load(8*N + 6);
    end
    // R9: reset in the middle of loading, then full restart
    for (int i = 0; i < 256; i++) vmem[i] = 8'($urandom);
    apply_reset();
    run_load(13);
    apply_reset();
    run_load(8*N + 6);
    check_ctx_static();
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end
endmodule